// File: doc/BRIEF.md
# Split-Latency State Machine Output Stage

This block is the output end of a small programmable sequencer. A 16-entry transition table picks the next state from the current state and a 1-bit condition. Two per-state output tables drive two output buses that differ in latency. The early bus is loaded from the entry of the state being entered, so it leads by one clock. The normal bus is loaded from the entry of the state being left, so it trails by one clock. A change that a state makes appears on the early bus one cycle before the matching change on the normal bus.

The tables are written through an address/data/write-enable port while the sequencer is stopped. A commit pulse then marks the configuration as loaded. A start pulse carries the starting value of the early bus, because that value does not come from any table entry. A start that arrives before the commit is refused, and a one-cycle error flag reports it. A stop pulse halts the sequencer. Both buses and the state then hold their last values until the next start.

Top module: `split_lat_fsm_out`

## Requirements
- R1: After reset the early bus, the normal bus, the state output and the error flag are all zero, and the sequencer is stopped.
- R2: When the sequencer is stopped and the configuration is loaded, a start pulse takes effect at the next edge. The state becomes 0, the early bus takes the start value, and the sequencer runs.
- R3: At each edge while running without stop, the state moves to the table entry for the current state. The entry used is the one at sel 0 when the condition is 0, and the one at sel 1 when the condition is 1.
- R4: At that same edge, the early bus takes the early-table entry (sel 2) of the state being entered.
- R5: At that same edge, the normal bus takes the normal-table entry (sel 3) of the state being left. Each state's normal value therefore appears one cycle after its early value.
- R6: A start pulse received before a commit has been registered is ignored. A start in the same cycle as the commit counts as before it. The error flag is high for exactly the cycle after each refused start.
- R7: A stop pulse while running halts the sequencer at the next edge. While stopped, the state and both buses keep their values.
- R8: A table write (cfg_we with cfg_sel, cfg_addr and cfg_data) takes effect only while stopped. A write while running leaves every table entry unchanged.
- R9: A start while running is ignored and raises no error. This holds even when the start arrives in the same cycle as stop, and in that case the sequencer stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Table write enable |
| cfg_sel | input | 2 | Table select: 0 next on cond 0, 1 next on cond 1, 2 early, 3 normal |
| cfg_addr | input | SW (4) | State index written |
| cfg_data | input | DW (8) | Write data (low SW bits for next-state tables) |
| cfg_commit | input | 1 | Marks the configuration as loaded |
| start | input | 1 | Start request |
| start_early | input | EW (8) | Early-bus value loaded at start |
| stop | input | 1 | Halt request |
| cond | input | 1 | Transition condition |
| early_out | output | EW (8) | Early output bus |
| norm_out | output | NW (8) | Normal output bus |
| cur_state | output | SW (4) | Current state |
| start_err | output | 1 | One-cycle refused-start flag |

## Verification
Two pairs of events can fall in the same cycle, and the bench drives each pair on purpose. A commit and a start are issued together on an unloaded block, which must count as a refused start with the error flag raised. Later, stop and start are issued together on a running block, which must stop with no error. A behavioural reference model, advanced at every edge from the same inputs, judges both cases, and the early-before-normal ordering is compared on every clock.

// File: rtl/split_lat_fsm_out.sv
module split_lat_fsm_out #(
  parameter int SW = 4,
  parameter int EW = 8,
  parameter int NW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [SW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_data,
  input  logic          cfg_commit,
  input  logic          start,
  input  logic [EW-1:0] start_early,
  input  logic          stop,
  input  logic          cond,
  output logic [EW-1:0] early_out,
  output logic [NW-1:0] norm_out,
  output logic [SW-1:0] cur_state,
  output logic          start_err
);
  localparam int NSTATE = 1 << SW;

  logic [SW-1:0] nxt0_t [NSTATE];
  logic [SW-1:0] nxt1_t [NSTATE];
  logic [EW-1:0] ear_t  [NSTATE];
  logic [NW-1:0] nrm_t  [NSTATE];

  logic          run_q, loaded_q;
  logic [SW-1:0] state_q;
  logic [EW-1:0] early_q;
  logic [NW-1:0] norm_q;
  logic          err_q;

  wire           tab_wr  = cfg_we && !run_q;
  wire           go      = start && !run_q && loaded_q;
  wire           refuse  = start && !run_q && !loaded_q;
  wire           advance = run_q && !stop;
  wire [SW-1:0]  nxt     = cond ? nxt1_t[state_q] : nxt0_t[state_q];

  always_ff @(posedge clk) begin
    if (tab_wr) begin
      case (cfg_sel)
        2'd0: nxt0_t[cfg_addr] <= cfg_data[SW-1:0];
        2'd1: nxt1_t[cfg_addr] <= cfg_data[SW-1:0];
        2'd2: ear_t[cfg_addr]  <= cfg_data[EW-1:0];
        default: nrm_t[cfg_addr] <= cfg_data[NW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      loaded_q <= 1'b0;
      state_q  <= '0;
      early_q  <= '0;
      norm_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= refuse;
      if (cfg_commit) loaded_q <= 1'b1;
      if (go) begin
        run_q   <= 1'b1;
        state_q <= '0;
        early_q <= start_early;
      end else if (advance) begin
        state_q <= nxt;
        early_q <= ear_t[nxt];
        norm_q  <= nrm_t[state_q];
      end else if (run_q) begin
        run_q <= 1'b0;
      end
    end
  end

  assign early_out = early_q;
  assign norm_out  = norm_q;
  assign cur_state = state_q;
  assign start_err = err_q;

  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !run_q && loaded_q |=> run_q && cur_state == '0 && early_out == $past(start_early));

  p_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start && !loaded_q |=> start_err && (cur_state == $past(cur_state) || $past(run_q)));

  p_err_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_err |-> !run_q);

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !start |=> $stable(cur_state) && $stable(early_out) && $stable(norm_out) && !run_q);

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && start |=> !start_err);

  p_keep_running_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !stop |=> run_q);
endmodule

// File: tb/split_lat_fsm_out_tb.sv
module split_lat_fsm_out_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_commit = 1'b0, start = 1'b0, stop = 1'b0, cond = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [3:0] cfg_addr = 4'd0;
  logic [7:0] cfg_data = 8'd0, start_early = 8'd0;
  logic [7:0] early_out, norm_out;
  logic [3:0] cur_state;
  logic       start_err;

  int n_run = 0, n_fail = 0;
  string tag = "R1";

  int m_n0[16], m_n1[16], m_e[16], m_nt[16];
  int m_state = 0, m_early = 0, m_norm = 0;
  bit m_run = 0, m_loaded = 0, m_err = 0;

  always #4 clk = ~clk;

  split_lat_fsm_out dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .cfg_commit(cfg_commit), .start(start), .start_early(start_early),
    .stop(stop), .cond(cond), .early_out(early_out), .norm_out(norm_out),
    .cur_state(cur_state), .start_err(start_err)
  );

  task automatic chk(input string t, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(tag, "state R3", cur_state, m_state);
    chk(tag, "early R4", early_out, m_early);
    chk(tag, "normal R5", norm_out, m_norm);
    chk(tag, "err R6", start_err, m_err);
  endtask

  task automatic model_edge();
    int ns;
    m_err = 0;
    if (start && !m_run) begin
      if (m_loaded) begin m_run = 1; m_state = 0; m_early = start_early; end
      else m_err = 1;
    end else if (m_run) begin
      if (stop) m_run = 0;
      else begin
        ns = cond ? m_n1[m_state] : m_n0[m_state];
        m_norm = m_nt[m_state];
        m_early = m_e[ns];
        m_state = ns;
      end
    end
    if (cfg_we && !m_run_before) begin end
  endtask

  bit m_run_before;

  task automatic cyc();
    m_run_before = m_run;
    @(posedge clk);
    if (cfg_we && !m_run_before) begin
      case (cfg_sel)
        2'd0: m_n0[cfg_addr] = cfg_data[3:0];
        2'd1: m_n1[cfg_addr] = cfg_data[3:0];
        2'd2: m_e[cfg_addr] = cfg_data;
        default: m_nt[cfg_addr] = cfg_data;
      endcase
    end
    model_edge();
    if (cfg_commit) m_loaded = 1;
    @(negedge clk);
    compare_all();
    cfg_we = 0; cfg_commit = 0; start = 0; stop = 0;
  endtask

  task automatic wr(input int sel, input int a, input int d);
    cfg_we = 1; cfg_sel = 2'(sel); cfg_addr = 4'(a); cfg_data = 8'(d);
    cyc();
  endtask

  task automatic load_tables(input int salt);
    for (int s = 0; s < 16; s++) begin
      wr(0, s, (s + 1) % 16);
      wr(1, s, (s * 5 + 3 + salt) % 16);
      wr(2, s, ((s * 17) ^ 8'h5A ^ salt) & 8'hFF);
      wr(3, s, ((s * 29 + 7) ^ salt) & 8'hFF);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1", "reset state", cur_state, 0);
    chk("R1", "reset early", early_out, 0);
    chk("R1", "reset normal", norm_out, 0);
    chk("R1", "reset err", start_err, 0);
    rst_n = 1;
    cyc();
    tag = "R6";
    start = 1; start_early = 8'hC3; cyc();
    chk("R6", "refused start err", start_err, 1);
    cyc();
    chk("R6", "err one cycle", start_err, 0);
    tag = "R8";
    load_tables(0);
    tag = "R6";
    cfg_commit = 1; start = 1; start_early = 8'h11; cyc();
    chk("R6", "start with commit refused", start_err, 1);
    tag = "R2";
    start = 1; start_early = 8'hA5; cyc();
    chk("R2", "start early value", early_out, 8'hA5);
    chk("R2", "start state", cur_state, 0);
    tag = "R5";
    for (int i = 0; i < 40; i++) begin
      int prev;
      prev = cur_state;
      cond = ((i * 7) % 3) == 0;
      cyc();
      chk("R5", "normal lags early", norm_out, m_nt[prev]);
      chk("R4", "early of entered", early_out, m_e[cur_state]);
    end
    tag = "R8";
    wr(2, 4, 8'hEE);
    wr(3, 0, 8'h01);
    wr(0, 5, 0);
    tag = "R9";
    start = 1; start_early = 8'h77; cyc();
    chk("R9", "busy start no err", start_err, 0);
    for (int i = 0; i < 20; i++) begin cond = i[0]; cyc(); end
    tag = "R9";
    start = 1; stop = 1; cyc();
    chk("R9", "stop wins no err", start_err, 0);
    tag = "R7";
    for (int i = 0; i < 6; i++) begin cond = ~cond; cyc(); end
    tag = "R8";
    load_tables(3);
    tag = "R2";
    start = 1; start_early = 8'h3C; cyc();
    tag = "R3";
    for (int i = 0; i < 50; i++) begin cond = (i % 5) > 1; cyc(); end
    tag = "R7";
    stop = 1; cyc();
    for (int i = 0; i < 5; i++) cyc();
    tag = "R6";
    start = 1; start_early = 8'h5E; cyc();
    chk("R6", "loaded start no err", start_err, 0);
    for (int i = 0; i < 10; i++) cyc();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule